// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sits between a simple processor core and a shared external bus. The core raises a request with a 16-bit segment, a 16-bit offset, a direction, a memory-or-I/O choice and write data. The controller adds the segment shifted left by four bits to the offset, keeps the low 20 bits as the physical address, and runs one bus cycle. The low sixteen lines carry the address first and then the data. The upper four address bits stay on their own lines for the whole cycle.

Each cycle has the states T1, T2, T3 and T4. While the external ready input is low, wait states are added after T3. An address-latch strobe marks T1. A read or write strobe is active from T2 until the data has been transferred. A select line tells memory cycles from I/O cycles. When the cycle ends, the core receives the captured read data and a one-clock done pulse. The shared lines are modelled as separate output, output-enable and input buses, so an external pad or tristate stage can join them.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: The physical address is (segment << 4) + offset, truncated to 20 bits. Bits 15:0 appear on `bus_ad_out` in T1. Bits 19:16 appear on `bus_a_hi` from T1 through T4 and stay stable through the cycle. `bus_a_hi` is 0 when idle.
- R2: `bus_ale` is high for exactly the one clock of T1 and low in every other state.
- R3: A request accepted on a clock edge gives T1 in the next clock, then T2 and T3, then any wait states, then T4, then idle. A cycle without waits therefore spans four clocks.
- R4: On a read, `bus_rd` is high (active-high) from T2 through the last T3 or wait state. On a write, `bus_wr` behaves the same way. Both strobes are low in T1, T4 and idle, and they are never high together.
- R5: `bus_rdy` is sampled only at the end of T3 and at the end of each wait state. Each low sample adds one wait state. Its value at the end of T2 has no effect.
- R6: On a read, `bus_ad_in` is captured at the edge where the bus leaves T3 or a wait state with `bus_rdy` high. The captured value is shown on `rsp_rdata` from T4 and is held through later write cycles until the next read captures new data.
- R7: `bus_ad_oe` is high in T1. On a write it stays high from T2 through T4, and `bus_ad_out` carries the write data. On a read it is low from T2 onward. It is low when idle.
- R8: `bus_mio` equals the request's memory flag (1 for memory, 0 for I/O) from T1 through T4 and is 0 when idle.
- R9: `req_ready` is high only when idle. A request is taken only on an edge where `req_ready` and `req_valid` are both high. Request inputs that change, or that are presented, during a cycle have no effect on that cycle.
- R10: `rsp_done` is high for exactly one clock, during T4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | 16 | Last captured read data |
| bus_ad_out | output | 16 | Shared lines, driven value |
| bus_ad_oe | output | 1 | Shared lines output enable |
| bus_ad_in | input | 16 | Shared lines, received value |
| bus_a_hi | output | 4 | Address bits 19:16 |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_mio | output | 1 | Memory (1) or I/O (0) select |
| bus_rdy | input | 1 | External ready; low requests a wait state |

## Verification
Two events can fall on the same clock. The first pair is the end of one cycle and a request that is still pending: while T4 raises the done pulse, `req_valid` is held high. The bench holds `req_valid` high through whole cycles, back to back, and expects exactly one idle clock with `req_ready` high before the next address strobe. The second pair is the capture of read data and the release of a wait state. `bus_rdy` rises in the same clock as the valid read word. Before that clock the bench drives a different word on `bus_ad_in`, so a capture one clock too early or too late shows up as a wrong `rsp_rdata` in T4.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int PA_W      = 20;
    localparam int AD_W      = 16;
    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int HI_W      = PA_W - AD_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic            write;
        logic            mem;
        logic [PA_W-1:0] pa;
        logic [AD_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] ofs;
        base = PA_W'({seg, {SEG_SHIFT{1'b0}}});
        ofs  = PA_W'(off);
        return base + ofs;
    endfunction

    function automatic logic strobe_phase(input bus_state_e st);
        return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
    endfunction

    function automatic logic data_phase(input bus_state_e st);
        return strobe_phase(st) || (st == ST_T4);
    endfunction

endpackage

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [AD_W-1:0]  req_wdata,
    output bus_req_t         cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (accept) begin
            cur.write <= req_write;
            cur.mem   <= req_mem;
            cur.pa    <= phys_addr(req_seg, req_off);
            cur.wdata <= req_wdata;
        end
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       bus_rdy,
    output logic       accept,
    output bus_state_e state
);

    bus_state_e nxt;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = accept ? ST_T1 : ST_IDLE;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = bus_rdy ? ST_T4 : ST_TW;
            ST_TW:   nxt = bus_rdy ? ST_T4 : ST_TW;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_state_e      state,
    input  bus_req_t        cur,
    input  logic [AD_W-1:0] bus_ad_in,
    input  logic            bus_rdy,
    output logic [AD_W-1:0] bus_ad_out,
    output logic            bus_ad_oe,
    output logic [HI_W-1:0] bus_a_hi,
    output logic            bus_ale,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic            bus_mio,
    output logic            rsp_done,
    output logic [AD_W-1:0] rsp_rdata
);

    logic in_cycle;
    logic addr_phase;
    logic capture;

    assign in_cycle   = (state != ST_IDLE);
    assign addr_phase = (state == ST_T1);
    assign capture    = !cur.write && ((state == ST_T3) || (state == ST_TW)) && bus_rdy;

    always_comb begin
        bus_ad_out = '0;
        if (addr_phase)
            bus_ad_out = cur.pa[AD_W-1:0];
        else if (cur.write && data_phase(state))
            bus_ad_out = cur.wdata;
    end

    assign bus_ad_oe = addr_phase || (cur.write && data_phase(state));
    assign bus_a_hi  = in_cycle ? cur.pa[PA_W-1:AD_W] : '0;
    assign bus_ale   = addr_phase;
    assign bus_rd    = !cur.write && strobe_phase(state);
    assign bus_wr    = cur.write && strobe_phase(state);
    assign bus_mio   = in_cycle && cur.mem;
    assign rsp_done  = (state == ST_T4);

    always_ff @(posedge clk) begin
        if (rst)          rsp_rdata <= '0;
        else if (capture) rsp_rdata <= bus_ad_in;
    end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [AD_W-1:0]  req_wdata,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [AD_W-1:0]  rsp_rdata,
    output logic [AD_W-1:0]  bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [AD_W-1:0]  bus_ad_in,
    output logic [HI_W-1:0]  bus_a_hi,
    output logic             bus_ale,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             bus_mio,
    input  logic             bus_rdy
);

    bus_state_e state;
    bus_req_t   cur;
    logic       accept;

    mbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_rdy   (bus_rdy),
        .accept    (accept),
        .state     (state)
    );

    mbus_req_latch u_lat (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_wdata (req_wdata),
        .cur       (cur)
    );

    mbus_drive u_drv (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .cur        (cur),
        .bus_ad_in  (bus_ad_in),
        .bus_rdy    (bus_rdy),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_a_hi   (bus_a_hi),
        .bus_ale    (bus_ale),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_mio    (bus_mio),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata)
    );

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/mbus_cycle_chk.sv
module mbus_cycle_chk
    import mbus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_done,
    input logic            bus_ad_oe,
    input logic [HI_W-1:0] bus_a_hi,
    input logic            bus_ale,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic            bus_rdy
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);                                          // R2

    AST_ACCEPT_TO_ALE: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> bus_ale);                          // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));                                           // R4

    AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!bus_rd && !bus_wr && !bus_ale));                 // R4

    AST_RD_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_rdy) |=> bus_rd);                               // R5

    AST_WR_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rdy) |=> bus_wr);                               // R5

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> bus_ad_oe);                                         // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_ale && !bus_rd && !bus_wr && !rsp_done && !bus_ad_oe)); // R9

    AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !bus_ale) |-> $stable(bus_a_hi));                // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);                                        // R10

endmodule

bind mbus_cycle_ctrl mbus_cycle_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_ad_oe (bus_ad_oe),
    .bus_a_hi  (bus_a_hi),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdy   (bus_rdy)
);

// File: tb/sim_mbus_cycle_ctrl.sv
module sim_mbus_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in = '0;
    logic [3:0]  bus_a_hi;
    logic        bus_ale;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_mio;
    logic        bus_rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    mbus_cycle_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_seg(req_seg), .req_off(req_off),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_a_hi(bus_a_hi), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_mio(bus_mio), .bus_rdy(bus_rdy)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    // Behavioural expectation of one whole bus cycle, checked every clock.
    task automatic run_cycle(input logic w, input logic m, input logic [15:0] seg,
                             input logic [15:0] off, input logic [15:0] wd,
                             input logic [15:0] rv, input int waits, input bit hold);
        logic [19:0] pa;
        pa = {seg, 4'h0} + {4'h0, off};
        chk_eq("R9", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = w; req_mem = m;
        req_seg = seg; req_off = off; req_wdata = wd;
        bus_rdy = 1'b1;
        @(negedge clk);                                   // T1
        chk_eq("R2", "ale in T1", {31'd0, bus_ale}, 32'd1);
        chk_eq("R1", "low address in T1", {16'd0, bus_ad_out}, {16'd0, pa[15:0]});
        chk_eq("R7", "oe in T1", {31'd0, bus_ad_oe}, 32'd1);
        chk_eq("R1", "high address in T1", {28'd0, bus_a_hi}, {28'd0, pa[19:16]});
        chk_eq("R8", "mio in T1", {31'd0, bus_mio}, {31'd0, m});
        chk_eq("R4", "no strobe in T1", {30'd0, bus_rd, bus_wr}, 32'd0);
        chk_eq("R9", "busy in T1", {31'd0, req_ready}, 32'd0);
        if (!hold) req_valid = 1'b0;
        req_seg = ~seg; req_off = ~off; req_wdata = ~wd; req_write = ~w; req_mem = ~m;
        bus_rdy = 1'b0;                                   // must not stretch T2 (R5)
        bus_ad_in = ~rv;
        @(negedge clk);                                   // T2
        chk_eq("R2", "ale low in T2", {31'd0, bus_ale}, 32'd0);
        chk_eq("R4", "strobes in T2", {30'd0, bus_rd, bus_wr}, {30'd0, !w, w});
        chk_eq("R7", "oe in T2", {31'd0, bus_ad_oe}, {31'd0, w});
        if (w) chk_eq("R7", "write data in T2", {16'd0, bus_ad_out}, {16'd0, wd});
        chk_eq("R9", "latched high address in T2", {28'd0, bus_a_hi}, {28'd0, pa[19:16]});
        chk_eq("R8", "mio in T2", {31'd0, bus_mio}, {31'd0, m});
        bus_rdy = (waits == 0);
        bus_ad_in = (waits == 0) ? rv : ~rv;
        @(negedge clk);                                   // T3
        chk_eq("R3", "strobes in T3", {30'd0, bus_rd, bus_wr}, {30'd0, !w, w});
        chk_eq("R5", "no done in T3", {31'd0, rsp_done}, 32'd0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);                               // wait state
            chk_eq("R5", "strobe held in wait", {30'd0, bus_rd, bus_wr}, {30'd0, !w, w});
            chk_eq("R5", "no done in wait", {31'd0, rsp_done}, 32'd0);
            chk_eq("R1", "high address in wait", {28'd0, bus_a_hi}, {28'd0, pa[19:16]});
            if (w) chk_eq("R7", "write data in wait", {16'd0, bus_ad_out}, {16'd0, wd});
            else   chk_eq("R7", "released in wait", {31'd0, bus_ad_oe}, 32'd0);
            bus_rdy = (i == waits - 1);
            bus_ad_in = (i == waits - 1) ? rv : ~rv;
        end
        @(negedge clk);                                   // T4
        chk_eq("R10", "done in T4", {31'd0, rsp_done}, 32'd1);
        chk_eq("R4", "strobes off in T4", {30'd0, bus_rd, bus_wr}, 32'd0);
        chk_eq("R7", "oe in T4", {31'd0, bus_ad_oe}, {31'd0, w});
        chk_eq("R8", "mio in T4", {31'd0, bus_mio}, {31'd0, m});
        if (!w) last_rd = rv;
        chk_eq("R6", "read data in T4", {16'd0, rsp_rdata}, {16'd0, last_rd});
        bus_rdy = 1'b1;
        bus_ad_in = 16'h5A5A;
        @(negedge clk);                                   // idle
        chk_eq("R10", "done cleared", {31'd0, rsp_done}, 32'd0);
        chk_eq("R3", "idle after T4", {31'd0, req_ready}, 32'd1);
        chk_eq("R2", "ale low idle", {31'd0, bus_ale}, 32'd0);
        chk_eq("R8", "idle bus lines", {26'd0, bus_mio, bus_ad_oe, bus_a_hi}, 32'd0);
        chk_eq("R6", "read data held", {16'd0, rsp_rdata}, {16'd0, last_rd});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL R3 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R9", "reset ready", {31'd0, req_ready}, 32'd1);
        chk_eq("R2", "reset strobes", {28'd0, bus_ale, bus_rd, bus_wr, rsp_done}, 32'd0);
        chk_eq("R6", "reset rdata", {16'd0, rsp_rdata}, 32'd0);
        // idle with ready low and no request: nothing starts
        bus_rdy = 1'b0;
        @(negedge clk);
        chk_eq("R9", "no request stays idle", {31'd0, bus_ale}, 32'd0);
        run_cycle(1'b0, 1'b1, 16'h1234, 16'h5678, 16'h0000, 16'hBEEF, 0, 1'b0);
        run_cycle(1'b1, 1'b0, 16'h4000, 16'h8000, 16'hC0DE, 16'h0000, 0, 1'b0);
        run_cycle(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h1357, 3, 1'b0);
        run_cycle(1'b1, 1'b1, 16'hF000, 16'h0010, 16'hA5A5, 16'h0000, 2, 1'b0);
        run_cycle(1'b0, 1'b0, 16'h0000, 16'h0003, 16'h0000, 16'h2468, 1, 1'b1);
        run_cycle(1'b1, 1'b0, 16'hABCD, 16'hEF01, 16'h7777, 16'h0000, 0, 1'b1);
        run_cycle(1'b0, 1'b1, 16'h8001, 16'h7FFF, 16'h0000, 16'h9ABC, 5, 1'b0);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule